// File: doc/BRIEF.md
# Shared Interrupt Source Controller

This block collects a group of external interrupt lines, whose count is a multiple of eight, and turns them into one interrupt request per processor element. Each line has its own pending flag and its own sense setting: active level, level or edge, and single or dual edge. A per-source enable mask gates every pending flag before it reaches a processor element.

Software drives the block through a simple 32-bit register port with a write strobe, a byte address and write data. Reads return data combinationally for the address presented. Enables change only through a set-register and a clear-register; a writable "1" selects the source and a "0" leaves it alone. A single trigger register lets software raise or acknowledge a pending edge by number. Each source carries a routing word that picks one destination element, a delivery enable and an output pin number.

Reads of pending and enable status return one bit per source. Source s sits in bit s%32 of the word at byte offset 4*(s/32) from the start of the region.

Top module: `sirq_top`

## Requirements
- R1: Reset is synchronous and active high. After reset every source is disabled, active-high (polarity 1), level-sensed (trigger 0), single-edge (dual 0), has an all-zero routing word, and every request output is low.
- R2: A write to the mask-set region (base 0x0A0) enables exactly the sources whose data bit is 1. Sources whose data bit is 0 keep their enable state.
- R3: A write to the mask-clear region (base 0x0C0) disables exactly the sources whose data bit is 1. Sources whose data bit is 0 keep their enable state.
- R4: A level-sensed source shows pending one clock after its input changes. Pending equals the input when polarity is 1 and equals the inverted input when polarity is 0. The polarity, trigger and dual regions (bases 0x040, 0x060, 0x080) are read/write bit vectors.
- R5: A single-edge source (trigger 1, dual 0) becomes pending on a rising input when polarity is 1 and on a falling input when polarity is 0. It stays pending after the input returns to idle.
- R6: A dual-edge source (trigger 1, dual 1) becomes pending on every input transition in either direction, whatever its polarity bit.
- R7: A write to the trigger register (0x004) selects the source given in data bits [7:0]. Data bit 31 = 1 sets that source's edge pending and bit 31 = 0 clears it, which acknowledges it. On a level-sensed source such a write has no effect.
- R8: The info register (0x000) reads the number of source groups minus one in bits [15:8] and the number of processor elements minus one in bits [7:0].
- R9: Enable status (base 0xE0) and pending status (base 0x100) read as 32-bit words at consecutive 4-byte offsets, with one bit per source.
- R10: Each source s has a read/write routing word at 0x400+4*s. Bits [7:0] hold the destination element, bits [13:8] the pin number, and bit 31 the delivery enable.
- R11: Request output p is high exactly when some source is pending, enabled, has delivery enabled, and has destination p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_src | input | 8*NUM_GROUPS | External interrupt inputs |
| pe_irq | output | NUM_PE | Interrupt request per processor element |

## Verification
The hardest state to reach is a latched edge that outlives its input. Reaching it needs a sequence: configure the edge and polarity settings, acknowledge whatever the mode switch left behind, make a transition, and then return the input to idle before any read. The bench walks shared 32-bit patterns through rising, falling and dual-edge modes in turn. Each expected pending word is predicted from the previous and the new input pattern. Trigger-register set and clear sweeps then cover every source number one at a time, and the request outputs are predicted from the routing words the bench wrote.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int ADDR_W = 12;
    localparam int DEST_W = 8;
    localparam int PIN_W  = 6;

    localparam logic [ADDR_W-1:0] A_INFO  = 12'h000;
    localparam logic [ADDR_W-1:0] A_WEDGE = 12'h004;
    localparam logic [ADDR_W-1:0] A_POL   = 12'h040;
    localparam logic [ADDR_W-1:0] A_TRIG  = 12'h060;
    localparam logic [ADDR_W-1:0] A_DUAL  = 12'h080;
    localparam logic [ADDR_W-1:0] A_MSET  = 12'h0A0;
    localparam logic [ADDR_W-1:0] A_MCLR  = 12'h0C0;
    localparam logic [ADDR_W-1:0] A_MASK  = 12'h0E0;
    localparam logic [ADDR_W-1:0] A_PEND  = 12'h100;
    localparam logic [ADDR_W-1:0] A_ROUTE = 12'h400;

    localparam int WEDGE_SET_BIT = 31;
    localparam int ROUTE_EN_BIT  = 31;
    localparam int ROUTE_PIN_LSB = 8;

    typedef struct packed {
        logic              deliver;
        logic [PIN_W-1:0]  pin;
        logic [DEST_W-1:0] dest;
    } route_t;

    function automatic route_t route_unpack(input logic [31:0] w);
        route_t r;
        r.deliver = w[ROUTE_EN_BIT];
        r.pin     = w[ROUTE_PIN_LSB +: PIN_W];
        r.dest    = w[DEST_W-1:0];
        return r;
    endfunction

    function automatic logic [31:0] route_pack(input route_t r);
        logic [31:0] w;
        w = '0;
        w[ROUTE_EN_BIT]             = r.deliver;
        w[ROUTE_PIN_LSB +: PIN_W]   = r.pin;
        w[DEST_W-1:0]               = r.dest;
        return w;
    endfunction

    function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                    input int idx);
        return base + ADDR_W'(idx * 4);
    endfunction

endpackage

// File: rtl/sirq_cell.sv
module sirq_cell
    import sirq_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              src,
    output logic              pol_q,
    output logic              trig_q,
    output logic              dual_q,
    output logic              mask_q,
    output logic              pend_q,
    output route_t            route_q
);
    localparam int WORD = IDX / 32;
    localparam int BIT  = IDX % 32;

    logic prev_q;
    logic wr_pol, wr_trig, wr_dual, wr_mset, wr_mclr, wr_route, wedge_hit;
    logic rise, fall, edge_hit, lvl_act, pend_n;

    assign wr_pol    = wr && (addr == word_addr(A_POL, WORD));
    assign wr_trig   = wr && (addr == word_addr(A_TRIG, WORD));
    assign wr_dual   = wr && (addr == word_addr(A_DUAL, WORD));
    assign wr_mset   = wr && (addr == word_addr(A_MSET, WORD)) && wdata[BIT];
    assign wr_mclr   = wr && (addr == word_addr(A_MCLR, WORD)) && wdata[BIT];
    assign wr_route  = wr && (addr == word_addr(A_ROUTE, IDX));
    assign wedge_hit = wr && (addr == A_WEDGE) && (wdata[DEST_W-1:0] == DEST_W'(IDX));

    assign rise     = src & ~prev_q;
    assign fall     = ~src & prev_q;
    assign edge_hit = dual_q ? (rise | fall) : (pol_q ? rise : fall);
    assign lvl_act  = pol_q ? src : ~src;

    always_comb begin
        if (!trig_q) begin
            pend_n = lvl_act;
        end else if (edge_hit || (wedge_hit && wdata[WEDGE_SET_BIT])) begin
            pend_n = 1'b1;
        end else if (wedge_hit) begin
            pend_n = 1'b0;
        end else begin
            pend_n = pend_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q   <= 1'b1;
            trig_q  <= 1'b0;
            dual_q  <= 1'b0;
            mask_q  <= 1'b0;
            pend_q  <= 1'b0;
            prev_q  <= 1'b0;
            route_q <= '0;
        end else begin
            if (wr_pol)  pol_q  <= wdata[BIT];
            if (wr_trig) trig_q <= wdata[BIT];
            if (wr_dual) dual_q <= wdata[BIT];
            if (wr_mset)      mask_q <= 1'b1;
            else if (wr_mclr) mask_q <= 1'b0;
            if (wr_route) route_q <= route_unpack(wdata);
            prev_q <= src;
            pend_q <= pend_n;
        end
    end
endmodule

// File: rtl/sirq_router.sv
module sirq_router
    import sirq_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NPE  = 4
) (
    input  logic [NSRC-1:0]    pend,
    input  logic [NSRC-1:0]    mask,
    input  route_t [NSRC-1:0]  routes,
    output logic [NPE-1:0]     pe_irq
);
    for (genvar p = 0; p < NPE; p++) begin : g_pe
        always_comb begin
            pe_irq[p] = 1'b0;
            for (int s = 0; s < NSRC; s++) begin
                if (pend[s] && mask[s] && routes[s].deliver &&
                    routes[s].dest == DEST_W'(p)) begin
                    pe_irq[p] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sirq_readmux.sv
module sirq_readmux
    import sirq_pkg::*;
#(
    parameter int NGRP = 4,
    parameter int NPE  = 4
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NGRP*8-1:0]     pol,
    input  logic [NGRP*8-1:0]     trig,
    input  logic [NGRP*8-1:0]     dual,
    input  logic [NGRP*8-1:0]     mask,
    input  logic [NGRP*8-1:0]     pend,
    input  route_t [NGRP*8-1:0]   routes,
    output logic [31:0]           rdata
);
    localparam int NSRC = NGRP * 8;
    localparam int NW   = (NSRC + 31) / 32;

    logic [NW*32-1:0] pol_p, trig_p, dual_p, mask_p, pend_p;

    always_comb begin
        pol_p  = '0; pol_p[NSRC-1:0]  = pol;
        trig_p = '0; trig_p[NSRC-1:0] = trig;
        dual_p = '0; dual_p[NSRC-1:0] = dual;
        mask_p = '0; mask_p[NSRC-1:0] = mask;
        pend_p = '0; pend_p[NSRC-1:0] = pend;
    end

    always_comb begin
        rdata = '0;
        if (addr == A_INFO) begin
            rdata = {16'd0, 8'(NGRP - 1), 8'(NPE - 1)};
        end
        for (int w = 0; w < NW; w++) begin
            if (addr == word_addr(A_POL, w))  rdata = pol_p[w*32 +: 32];
            if (addr == word_addr(A_TRIG, w)) rdata = trig_p[w*32 +: 32];
            if (addr == word_addr(A_DUAL, w)) rdata = dual_p[w*32 +: 32];
            if (addr == word_addr(A_MASK, w)) rdata = mask_p[w*32 +: 32];
            if (addr == word_addr(A_PEND, w)) rdata = pend_p[w*32 +: 32];
        end
        for (int s = 0; s < NSRC; s++) begin
            if (addr == word_addr(A_ROUTE, s)) rdata = route_pack(routes[s]);
        end
    end
endmodule

// File: rtl/sirq_top.sv
module sirq_top
    import sirq_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_PE     = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [11:0]             bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NUM_GROUPS*8-1:0] irq_src,
    output logic [NUM_PE-1:0]       pe_irq
);
    localparam int NSRC = NUM_GROUPS * 8;

    logic [NSRC-1:0]   pol_v, trig_v, dual_v, mask_v, pend_v;
    route_t [NSRC-1:0] route_v;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        sirq_cell #(.IDX(g)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .wr      (bus_wr),
            .addr    (bus_addr),
            .wdata   (bus_wdata),
            .src     (irq_src[g]),
            .pol_q   (pol_v[g]),
            .trig_q  (trig_v[g]),
            .dual_q  (dual_v[g]),
            .mask_q  (mask_v[g]),
            .pend_q  (pend_v[g]),
            .route_q (route_v[g])
        );
    end

    sirq_router #(.NSRC(NSRC), .NPE(NUM_PE)) u_router (
        .pend   (pend_v),
        .mask   (mask_v),
        .routes (route_v),
        .pe_irq (pe_irq)
    );

    sirq_readmux #(.NGRP(NUM_GROUPS), .NPE(NUM_PE)) u_rd (
        .addr   (bus_addr),
        .pol    (pol_v),
        .trig   (trig_v),
        .dual   (dual_v),
        .mask   (mask_v),
        .pend   (pend_v),
        .routes (route_v),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk
    import sirq_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NPE  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [11:0]       bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NPE-1:0]    pe_irq,
    input logic [NSRC-1:0]   mask_v,
    input logic [NSRC-1:0]   pend_v,
    input logic [NSRC-1:0]   trig_v
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (mask_v == '0 && pe_irq == '0));

    // R11
    irq_needs_source_chk: assert property (@(posedge clk) disable iff (rst)
        (pe_irq != '0) |-> ((pend_v & mask_v) != '0));

    // R11
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_v == '0) |-> (pe_irq == '0));

    // R3
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MCLR && bus_wdata[0]) |=> !mask_v[0]);

    // R2
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MSET && bus_wdata[0]) |=> mask_v[0]);

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_v[0] && pend_v[0] &&
         !(bus_wr && bus_addr == A_WEDGE && !bus_wdata[WEDGE_SET_BIT] &&
           bus_wdata[7:0] == 8'd0) &&
         !(bus_wr && bus_addr == A_TRIG)) |=> pend_v[0]);
endmodule

bind sirq_top sirq_chk #(.NSRC(NUM_GROUPS * 8), .NPE(NUM_PE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pe_irq    (pe_irq),
    .mask_v    (mask_v),
    .pend_v    (pend_v),
    .trig_v    (trig_v)
);

// File: tb/sirq_top_tb.sv
module sirq_top_tb;
    import sirq_pkg::*;

    localparam int NG   = 4;
    localparam int NPE  = 4;
    localparam int NSRC = NG * 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NSRC-1:0]   irq_src = '0;
    logic [NPE-1:0]    pe_irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] mask_m;
    logic [31:0] route_m [NSRC];

    always #2 clk = ~clk;

    sirq_top #(.NUM_GROUPS(NG), .NUM_PE(NPE)) u_dut (
        .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .irq_src (irq_src), .pe_irq (pe_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        irq_src = v;
        @(negedge clk);
    endtask

    task automatic clear_all();
        for (int s = 0; s < NSRC; s++) wr(A_WEDGE, 32'(s));
    endtask

    function automatic logic [31:0] exp_irq(input logic [31:0] pend);
        logic [31:0] r;
        r = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (pend[s] && mask_m[s] && route_m[s][31])
                r[route_m[s][7:0]] = 1'b1;
        end
        return r;
    endfunction

    task automatic chk_pend(input string req, input logic [31:0] exp);
        rd_chk(req, A_PEND, exp);
        check({req, "/R11"}, 32'(pe_irq), exp_irq(exp));
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a, b, c, d, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R8 reset state and info
        rd_chk("R1 mask", A_MASK, 32'h0);
        rd_chk("R1 pend", A_PEND, 32'h0);
        rd_chk("R1 pol", A_POL, 32'hFFFF_FFFF);
        rd_chk("R1 trig", A_TRIG, 32'h0);
        rd_chk("R1 dual", A_DUAL, 32'h0);
        rd_chk("R1 route", word_addr(A_ROUTE, 5), 32'h0);
        check("R1 irq", 32'(pe_irq), 32'h0);
        rd_chk("R8 info", A_INFO, 32'h0000_0303);

        // R2 / R3 / R9 mask sweeps
        mask_m = '0;
        for (int s = 0; s < NSRC; s++) begin
            wr(A_MSET, 32'(1) << s);
            mask_m[s] = 1'b1;
            rd_chk("R2 set sweep R9", A_MASK, mask_m);
        end
        wr(A_MSET, 32'h0);
        rd_chk("R2 zero write", A_MASK, mask_m);
        for (int s = 0; s < NSRC; s += 3) begin
            wr(A_MCLR, 32'(1) << s);
            mask_m[s] = 1'b0;
            rd_chk("R3 clear sweep", A_MASK, mask_m);
        end
        wr(A_MCLR, 32'h0);
        rd_chk("R3 zero write", A_MASK, mask_m);
        wr(A_MSET, 32'hFFFF_FFFF);
        mask_m = 32'hFFFF_FFFF;
        rd_chk("R2 set all", A_MASK, mask_m);

        // R10 routing words
        for (int s = 0; s < NSRC; s++) begin
            route_m[s] = {(s % 8 != 7), 17'd0, 6'((s * 5) % 64), 8'(s % NPE)};
            wr(word_addr(A_ROUTE, s), route_m[s]);
        end
        for (int s = 0; s < NSRC; s++)
            rd_chk("R10 route", word_addr(A_ROUTE, s), route_m[s]);

        // R4 level sensing, both polarities
        a = 32'hA5C3_0F81;
        drive(a);
        chk_pend("R4 level high", a);
        drive(32'h1248_8421);
        chk_pend("R4 level high 2", 32'h1248_8421);
        wr(A_POL, 32'h0F0F_0F0F);
        rd_chk("R4 pol rw", A_POL, 32'h0F0F_0F0F);
        drive(a);
        chk_pend("R4 level mixed", ~(a ^ 32'h0F0F_0F0F));
        wr(A_MCLR, 32'h00FF_00FF);
        mask_m = 32'hFF00_FF00;
        drive(32'h0);
        chk_pend("R11 partial mask", 32'hF0F0_F0F0);
        wr(A_MSET, 32'hFFFF_FFFF);
        mask_m = 32'hFFFF_FFFF;

        // R5 single edge
        wr(A_POL, 32'hFFFF_FFFF);
        wr(A_TRIG, 32'hFFFF_FFFF);
        rd_chk("R4 trig rw", A_TRIG, 32'hFFFF_FFFF);
        drive(32'h0);
        clear_all();
        chk_pend("R7 clear all", 32'h0);
        b = 32'h3C96_5A11;
        drive(b);
        chk_pend("R5 rising", b);
        drive(32'h0);
        chk_pend("R5 held after idle", b);
        clear_all();
        chk_pend("R7 ack", 32'h0);
        wr(A_POL, 32'h0);
        drive(32'hFFFF_FFFF);
        chk_pend("R5 rising ignored at pol0", 32'h0);
        c = 32'h7E81_C33C;
        drive(c);
        chk_pend("R5 falling", ~c);
        clear_all();

        // R6 dual edge, polarity ignored
        wr(A_DUAL, 32'hFFFF_FFFF);
        rd_chk("R4 dual rw", A_DUAL, 32'hFFFF_FFFF);
        d = 32'h9999_6666;
        drive(d);
        chk_pend("R6 dual pol0", c ^ d);
        wr(A_POL, 32'hFFFF_FFFF);
        e = 32'h0F0F_F0F0;
        drive(e);
        chk_pend("R6 dual pol1", (c ^ d) | (d ^ e));
        clear_all();
        chk_pend("R7 clear dual", 32'h0);

        // R7 trigger register sweeps
        a = '0;
        for (int s = 0; s < NSRC; s++) begin
            wr(A_WEDGE, 32'h8000_0000 | 32'(s));
            a[s] = 1'b1;
            chk_pend("R7 set sweep", a);
        end
        for (int s = NSRC - 1; s >= 0; s -= 2) begin
            wr(A_WEDGE, 32'(s));
            a[s] = 1'b0;
            chk_pend("R7 clear sweep", a);
        end

        // R7 no effect on level sources
        wr(A_TRIG, 32'h0);
        wr(A_DUAL, 32'h0);
        drive(32'h0);
        chk_pend("R4 back to level", 32'h0);
        wr(A_WEDGE, 32'h8000_0003);
        chk_pend("R7 level ignores set", 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule